// File: doc/BRIEF.md
# Aligned PWM Channel with Selectable Clock Source

This block produces one pulse-width-modulated waveform from a master clock. The channel's counter is advanced by a tick chosen from one of two kinds of source. The first kind is a free-running power-of-two prescaler that offers divisions by 1 through 1024. The second kind is one of two linear dividers. Each linear divider counts ticks from a prescaler tap of its own choosing and divides them by an 8-bit factor.

The waveform has two settings. In left-aligned form the counter counts up and wraps. In center-aligned form the counter counts up to the period and then back down, so the pulse sits symmetrically about the middle of the period. A polarity bit chooses the level at which each period begins.

Period, duty, polarity and alignment are taken from the input pins. They become active only at a period boundary, so a running waveform never sees a half-applied setting. A one-cycle strobe marks every boundary. While the channel is disabled it holds its start level, and its counter waits at zero.

Top module: `pwm_chan`

## Requirements
- R1: With `clk_sel` = k for k in 0..10, the counter advances once every 2^k master clocks. A left-aligned period therefore lasts 2^k × PERIOD master clocks.
- R2: `clk_sel` = 11 selects linear divider A and `clk_sel` = 12 selects divider B. The selected divider emits one tick per FACTOR ticks of its own prescaler tap. With a FACTOR of 0 it emits no ticks, so no period completes.
- R3: In left-aligned mode (`center_in` = 0) the counter runs from 0 to PERIOD−1 and then wraps. A period lasts PERIOD ticks, and the output is at its start level for DUTY of those ticks.
- R4: In center-aligned mode (`center_in` = 1) the counter rises from 0 to PERIOD and falls back to 0. A period lasts 2 × PERIOD ticks. The output is at its start level for 2 × DUTY ticks, split equally between the two ends of the period.
- R5: The start level of each period equals the active polarity bit. During reset and after reset the output is low.
- R6: Values written to `period_in`, `duty_in`, `pol_in` and `center_in` while the channel is running take effect only at the next period end.
- R7: `period_end` is high for exactly one cycle after each reload of the active settings. It is never high unless the channel was enabled in the cycle before.
- R8: While `chan_en` is low, the output equals the start level, the counter sits at 0 and no strobe appears. When `chan_en` rises, a full period follows: with a 1-tick clock the first strobe arrives PERIOD cycles later.
- R9: If DUTY ≥ PERIOD, the output stays at its start level for the whole period. If DUTY = 0, the output stays at the opposite level for the whole period. Neither case produces a glitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| clk_sel | input | 4 | Clock source: 0..10 prescaler tap, 11 divider A, 12 divider B |
| diva_fac | input | 8 | Divider A factor (0 = off) |
| diva_tap | input | 4 | Prescaler tap feeding divider A |
| divb_fac | input | 8 | Divider B factor (0 = off) |
| divb_tap | input | 4 | Prescaler tap feeding divider B |
| period_in | input | 16 | Pending period, in ticks |
| duty_in | input | 16 | Pending duty, in ticks |
| pol_in | input | 1 | Pending start level |
| center_in | input | 1 | Pending alignment: 1 = center, 0 = left |
| pwm_out | output | 1 | Waveform |
| period_end | output | 1 | One-cycle period-boundary strobe |

## Verification
The hardest situation to reach from the ports is a setting change that lands in the middle of a running period. It must have no effect until the boundary. The bench waits for a strobe so that it knows the counter is at zero. It then writes a new duty and samples the output a known number of ticks later. At that point the old and the new duty would give opposite levels. After the next boundary the bench measures a whole period to confirm that the new duty has taken hold. Each divider and each alignment is measured the same way, always after two settling periods, because the free-running prescaler is not aligned to the enable.

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int PW   = 16,
  parameter int NTAP = 11,
  parameter int FW   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chan_en,
  input  logic [$clog2(NTAP+2)-1:0]     clk_sel,
  input  logic [FW-1:0]                 diva_fac,
  input  logic [$clog2(NTAP)-1:0]       diva_tap,
  input  logic [FW-1:0]                 divb_fac,
  input  logic [$clog2(NTAP)-1:0]       divb_tap,
  input  logic [PW-1:0]                 period_in,
  input  logic [PW-1:0]                 duty_in,
  input  logic                          pol_in,
  input  logic                          center_in,
  output logic                          pwm_out,
  output logic                          period_end
);
  localparam int SW  = $clog2(NTAP+2);
  localparam int TW  = $clog2(NTAP);
  localparam int PRW = NTAP - 1;

  logic [PRW-1:0]  pre_cnt;
  logic [NTAP-1:0] tap_tick;
  logic [FW-1:0]   fac_a [2];
  logic [TW-1:0]   tap_a [2];
  logic [1:0]      div_tick;
  logic            tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + PRW'(1);

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_first
      assign tap_tick[k] = 1'b1;
    end else begin : g_rest
      assign tap_tick[k] = &pre_cnt[k-1:0];
    end
  end

  assign fac_a[0] = diva_fac;
  assign fac_a[1] = divb_fac;
  assign tap_a[0] = diva_tap;
  assign tap_a[1] = divb_tap;

  for (genvar d = 0; d < 2; d++) begin : g_div
    logic [FW-1:0] dcnt;
    logic          src;
    logic          last;
    assign src  = (tap_a[d] < TW'(NTAP)) ? tap_tick[tap_a[d]] : 1'b0;
    assign last = (fac_a[d] != '0) && (dcnt >= fac_a[d] - FW'(1));
    assign div_tick[d] = src && last;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                dcnt <= '0;
      else if (fac_a[d] == '0)   dcnt <= '0;
      else if (src)              dcnt <= last ? '0 : dcnt + FW'(1);
  end

  always_comb begin
    if (clk_sel < SW'(NTAP))           tick = tap_tick[clk_sel];
    else if (clk_sel == SW'(NTAP))     tick = div_tick[0];
    else if (clk_sel == SW'(NTAP + 1)) tick = div_tick[1];
    else                               tick = 1'b0;
  end

  logic [PW-1:0] cnt, per_act, duty_act;
  logic          pol_act, ctr_act, dn;
  logic [PW:0]   cnt_inc;
  logic          top_hit, wrap, below;

  assign cnt_inc = {1'b0, cnt} + (PW+1)'(1);
  assign top_hit = cnt_inc >= {1'b0, per_act};
  assign wrap    = ctr_act ? (dn ? (cnt <= PW'(1)) : (per_act == '0)) : top_hit;
  assign below   = dn ? (cnt <= duty_act) : (cnt < duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; dn <= 1'b0; period_end <= 1'b0;
      per_act <= '0; duty_act <= '0; pol_act <= 1'b0; ctr_act <= 1'b0;
    end else if (!chan_en) begin
      cnt <= '0; dn <= 1'b0; period_end <= 1'b0;
      per_act <= period_in; duty_act <= duty_in;
      pol_act <= pol_in; ctr_act <= center_in;
    end else begin
      period_end <= 1'b0;
      if (tick) begin
        if (wrap) begin
          cnt <= '0; dn <= 1'b0; period_end <= 1'b1;
          per_act <= period_in; duty_act <= duty_in;
          pol_act <= pol_in; ctr_act <= center_in;
        end else if (ctr_act && !dn && top_hit) begin
          cnt <= per_act; dn <= 1'b1;
        end else if (dn) begin
          cnt <= cnt - PW'(1);
        end else begin
          cnt <= cnt_inc[PW-1:0];
        end
      end
    end
  end

  assign pwm_out = chan_en ? (below ? pol_act : ~pol_act) : pol_act;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          pol_in,
  input logic          pwm_out,
  input logic          period_end,
  input logic [PW-1:0] cnt,
  input logic [PW-1:0] per_act,
  input logic [PW-1:0] duty_act,
  input logic          pol_act,
  input logic          ctr_act,
  input logic          dn
);
  assert_strobe_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> $past(chan_en));

  assert_disabled_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && $past(!chan_en) && $past(rst_n)) |-> (pwm_out == $past(pol_in)));

  assert_disabled_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!chan_en) && $past(rst_n)) |-> (cnt == '0 && !period_end));

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (!$stable(duty_act) || !$stable(per_act)))
      |-> (period_end || $past(!chan_en)));

  assert_left_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !ctr_act && per_act != '0) |-> (cnt < per_act && !dn));

  assert_center_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && ctr_act) |-> (cnt <= per_act));

  assert_full_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && per_act != '0 && duty_act >= per_act) |-> (pwm_out == pol_act));

  assert_zero_duty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && per_act != '0 && duty_act == '0) |-> (pwm_out != pol_act));
endmodule

bind pwm_chan pwm_chan_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pol_in(pol_in),
  .pwm_out(pwm_out), .period_end(period_end), .cnt(cnt),
  .per_act(per_act), .duty_act(duty_act), .pol_act(pol_act),
  .ctr_act(ctr_act), .dn(dn)
);

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, chan_en, pol_in, center_in;
  logic [3:0]  clk_sel, diva_tap, divb_tap;
  logic [7:0]  diva_fac, divb_fac;
  logic [15:0] period_in, duty_in;
  logic        pwm_out, period_end;

  always #5 clk = ~clk;

  pwm_chan dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .clk_sel(clk_sel),
    .diva_fac(diva_fac), .diva_tap(diva_tap), .divb_fac(divb_fac), .divb_tap(divb_tap),
    .period_in(period_in), .duty_in(duty_in), .pol_in(pol_in), .center_in(center_in),
    .pwm_out(pwm_out), .period_end(period_end)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit wd = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd = 1'b1;
  end

  typedef struct packed {
    logic        ctr;
    logic        pol;
    logic [3:0]  sel;
    logic [15:0] per;
    logic [15:0] duty;
    logic [31:0] exp_per;
    logic [31:0] exp_hi;
  } vec_t;

  // divider A: factor 3 on tap 1 (6 clocks/tick); divider B: factor 5 on tap 0 (5 clocks/tick)
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 4'd0,  16'd10, 16'd3, 32'd10,   32'd3},
    '{1'b0, 1'b1, 4'd2,  16'd5,  16'd2, 32'd20,   32'd8},
    '{1'b1, 1'b0, 4'd1,  16'd6,  16'd2, 32'd24,   32'd8},
    '{1'b1, 1'b1, 4'd0,  16'd7,  16'd7, 32'd14,   32'd14},
    '{1'b0, 1'b0, 4'd11, 16'd4,  16'd1, 32'd24,   32'd6},
    '{1'b1, 1'b1, 4'd12, 16'd3,  16'd0, 32'd30,   32'd0},
    '{1'b0, 1'b0, 4'd10, 16'd2,  16'd1, 32'd2048, 32'd1024}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_strobe(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (n < 5000 && !wd) begin
      @(negedge clk);
      n++;
      if (period_end) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(output int per, output int hi, output bit ok);
    per = 0; hi = 0;
    wait_strobe(ok);
    if (!ok) return;
    do begin
      per++;
      if (pwm_out == pol_in) hi++;
      @(negedge clk);
    end while (!period_end && per < 5000 && !wd);
    ok = period_end;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.sel >= 4'd11) return "R2";
    if (v.ctr)          return "R4/R1";
    return "R3/R1";
  endfunction

  initial begin
    bit ok;
    int per, hi, n;
    rst_n = 1'b0; chan_en = 1'b0; pol_in = 1'b0; center_in = 1'b0;
    clk_sel = 4'd0; diva_fac = 8'd3; diva_tap = 4'd1; divb_fac = 8'd5; divb_tap = 4'd0;
    period_in = 16'd10; duty_in = 16'd3;
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R5", "reset output level", pwm_out, 0);
    chk(period_end == 1'b0, "R7", "reset strobe", period_end, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R5", "output after reset", pwm_out, 0);

    foreach (VECS[i]) begin
      chan_en = 1'b0;
      center_in = VECS[i].ctr; pol_in = VECS[i].pol; clk_sel = VECS[i].sel;
      period_in = VECS[i].per; duty_in = VECS[i].duty;
      @(negedge clk);
      chan_en = 1'b1;
      wait_strobe(ok);
      wait_strobe(ok);
      measure(per, hi, ok);
      chk(ok && per == int'(VECS[i].exp_per), tag_of(VECS[i]), $sformatf("vector %0d period", i),
          per, int'(VECS[i].exp_per));
      chk(ok && hi == int'(VECS[i].exp_hi), {tag_of(VECS[i]), "/R5"},
          $sformatf("vector %0d start-level cycles", i), hi, int'(VECS[i].exp_hi));
    end

    // R8: disabled holds start level and emits no strobe
    chan_en = 1'b0; pol_in = 1'b1; center_in = 1'b0; clk_sel = 4'd0;
    period_in = 16'd10; duty_in = 16'd3;
    repeat (3) @(negedge clk);
    n = 0;
    for (int c = 0; c < 50; c++) begin
      if (pwm_out !== 1'b1 || period_end !== 1'b0) n++;
      @(negedge clk);
    end
    chk(n == 0, "R8", "disabled: bad cycles", n, 0);

    // R8: enable restarts a full period from zero
    pol_in = 1'b0;
    @(negedge clk);
    chan_en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!period_end && n < 100);
    chk(n == 10, "R8", "cycles to first strobe after enable", n, 10);

    // R6: duty written mid-period waits for the boundary (strobe cycle has counter at 0)
    duty_in = 16'd8;
    repeat (5) @(negedge clk);
    chk(pwm_out == 1'b1, "R6", "level at count 5 keeps old duty", pwm_out, 1);
    measure(per, hi, ok);
    chk(ok && hi == 8, "R6", "start-level cycles with new duty", hi, 8);

    // R7: strobe lasts one cycle with a multi-tick period
    chan_en = 1'b0; clk_sel = 4'd2; period_in = 16'd5; duty_in = 16'd2;
    @(negedge clk);
    chan_en = 1'b1;
    wait_strobe(ok);
    @(negedge clk);
    chk(ok && period_end == 1'b0, "R7", "strobe width", period_end, 0);

    // R9: duty above period gives a constant start level in center mode
    chan_en = 1'b0; clk_sel = 4'd0; center_in = 1'b1; pol_in = 1'b0;
    period_in = 16'd4; duty_in = 16'd9;
    @(negedge clk);
    chan_en = 1'b1;
    wait_strobe(ok);
    measure(per, hi, ok);
    chk(ok && hi == 8 && per == 8, "R9", "duty>period start-level cycles", hi, 8);

    // R2: divider factor 0 stops the channel
    chan_en = 1'b0; clk_sel = 4'd11; diva_fac = 8'd0; center_in = 1'b0;
    pol_in = 1'b1; period_in = 16'd4; duty_in = 16'd2;
    @(negedge clk);
    chan_en = 1'b1;
    n = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (period_end || pwm_out !== 1'b1) n++;
    end
    chk(n == 0, "R2", "factor 0: strobes or level changes", n, 0);

    if (wd) chk(1'b0, "watchdog", "run expired", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule